// File: doc/BRIEF.md
# Iterative Integer Divider

A multi-cycle divider for 32-bit operands that returns only the quotient. A caller presents a dividend, a divisor and a signedness select, and pulses `start` while the unit is idle. The unit then converts both operands to magnitudes and counts the leading zeros of the dividend magnitude. It runs a restoring shift-and-subtract loop that yields one quotient bit per cycle, for only as many cycles as the dividend magnitude has significant bits. On the last iteration it restores the quotient's sign. The remainder exists internally and is thrown away. No overflow or carry indication is produced.

A zero divisor and a zero dividend both finish at once with a quotient of zero. For a zero divisor a dedicated status bit goes high. That bit and the quotient are registered and hold their value until the next division completes. Reset is synchronous and active low.

Top module: `intdiv_seq`

## Requirements
- R1: With `is_signed` = 0, both operands are unsigned and the quotient equals floor(dividend / divisor). Examples: 15/4 = 3, 4/15 = 0, 0x80000000/0x40000000 = 2.
- R2: With `is_signed` = 1, both operands are two's complement and the quotient is truncated toward zero. Examples: 15/4 = 3, -15/4 = -3, 4/-3 = -1, -4/-3 = 1.
- R3: A signed division of 0x80000000 by 0xFFFFFFFF (-1) returns 0x80000000 with `div_zero` = 0.
- R4: A divisor of 0 completes one cycle after `start` is accepted, with `quotient` = 0 and `div_zero` = 1. This holds in either mode.
- R5: Let b be the bit length of the dividend magnitude. For a nonzero dividend and divisor, `busy` is high for exactly b cycles after acceptance, and `done` rises b+1 cycles after the accepting edge is reached. A zero dividend with a nonzero divisor completes one cycle after acceptance, with `div_zero` = 0.
- R6: `done` is high for a single cycle per completed division and is never high together with `busy`.
- R7: `start` is accepted only while `busy` is low. A `start` that arrives while busy has no effect on the running division or its result.
- R8: Between completions, `quotient` and `div_zero` keep their last values.
- R9: While `rst_n` is low at a clock edge, `busy`, `done` and `div_zero` are cleared and `quotient` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division; taken when `busy` is low |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Numerator |
| divisor | input | 32 | Denominator |
| busy | output | 1 | Iteration loop running |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Result of the last completed division |
| div_zero | output | 1 | Last completed division had a zero divisor |

## Verification
The bench aims at the sign corners: mixed-sign operands, where a missing negation would give a result of the wrong sign, and the most negative value divided by -1, where a saturating or trapping design would return 0x7FFFFFFF or raise `div_zero`. It times every division against the dividend's bit length, so a design that skipped too few or too many leading zeros would assert `done` in the wrong cycle. A design that skipped too many would also return a truncated quotient. It divides by zero and zero by a nonzero value, and it fires `start` in the middle of a running division. A design with a stale status bit or one that restarted on a busy `start` would show a wrong `div_zero` or a corrupted quotient.

// File: rtl/intdiv_pkg.sv
// Package: shared width and controller state type for the iterative divider.
// Assumes operand and result widths are equal.
package intdiv_pkg;
    parameter int DIV_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/intdiv_lzc.sv
// Leading-zero counter: number of zero bits above the highest set bit of val.
// Returns W when val is zero. Purely combinational.
module intdiv_lzc #(
    parameter int W = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [CW-1:0] zeros
);
    // Scan upward so the highest set bit sets the final count.
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (val[i]) zeros = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/intdiv_prep.sv
// Operand preparation: magnitudes of both operands and the quotient sign.
// In unsigned mode operands pass through and the sign is positive.
// The most negative value maps to its own bit pattern, read as unsigned.
module intdiv_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    input  logic         is_signed,
    output logic [W-1:0] num_mag,
    output logic [W-1:0] den_mag,
    output logic         neg
);
    logic num_neg;
    logic den_neg;

    // Sign detection and conditional two's complement negation.
    always_comb begin
        num_neg = is_signed & num[W-1];
        den_neg = is_signed & den[W-1];
        num_mag = num_neg ? (~num + 1'b1) : num;
        den_mag = den_neg ? (~den + 1'b1) : den;
        neg     = num_neg ^ den_neg;
    end
endmodule

// File: rtl/intdiv_step.sv
// One restoring-division iteration.
// work holds the remaining dividend bits at the top and the quotient bits
// gathered so far at the bottom. Assumes rem < dsr on entry.
module intdiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] work,
    input  logic [W-1:0] dsr,
    output logic [W-1:0] rem_nx,
    output logic [W-1:0] work_nx
);
    logic [W:0] shifted;
    logic [W:0] trial;
    logic       qbit;

    // Shift in the next dividend bit, try the subtraction, restore on borrow.
    always_comb begin
        shifted = {rem, work[W-1]};
        trial   = shifted - {1'b0, dsr};
        qbit    = ~trial[W];
        rem_nx  = qbit ? trial[W-1:0] : shifted[W-1:0];
        work_nx = {work[W-2:0], qbit};
    end
endmodule

// File: rtl/intdiv_seq.sv
// Iterative quotient-only divider with start/busy/done handshake.
// Accepts start only when idle. A zero divisor or zero dividend finishes on
// the accepting edge. Otherwise the loop runs once per significant dividend bit.
// quotient and div_zero are registered and change only on completion.
// Synchronous active-low reset.
module intdiv_seq
    import intdiv_pkg::*;
#(
    parameter int W = DIV_W,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic         div_zero
);
    div_state_e    state_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  work_q;
    logic [W-1:0]  dsr_q;
    logic          neg_q;
    logic [CW-1:0] cnt_q;

    logic [W-1:0]  num_mag;
    logic [W-1:0]  den_mag;
    logic          neg_in;
    logic [CW-1:0] lead_zeros;
    logic [W-1:0]  rem_nx;
    logic [W-1:0]  work_nx;
    logic          accept;
    logic          trivial;

    intdiv_prep #(.W(W)) u_prep (
        .num       (dividend),
        .den       (divisor),
        .is_signed (is_signed),
        .num_mag   (num_mag),
        .den_mag   (den_mag),
        .neg       (neg_in)
    );

    intdiv_lzc #(.W(W)) u_lzc (
        .val   (num_mag),
        .zeros (lead_zeros)
    );

    intdiv_step #(.W(W)) u_step (
        .rem     (rem_q),
        .work    (work_q),
        .dsr     (dsr_q),
        .rem_nx  (rem_nx),
        .work_nx (work_nx)
    );

    // Acceptance and the cases that need no iteration.
    always_comb begin
        accept  = start && (state_q == ST_IDLE);
        trivial = (den_mag == '0) || (num_mag == '0);
    end

    // Controller and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rem_q    <= '0;
            work_q   <= '0;
            dsr_q    <= '0;
            neg_q    <= 1'b0;
            cnt_q    <= '0;
            done     <= 1'b0;
            quotient <= '0;
            div_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (trivial) begin
                            done     <= 1'b1;
                            quotient <= '0;
                            div_zero <= (den_mag == '0);
                        end else begin
                            state_q <= ST_RUN;
                            rem_q   <= '0;
                            work_q  <= num_mag << lead_zeros;
                            dsr_q   <= den_mag;
                            neg_q   <= neg_in;
                            cnt_q   <= CW'(W) - lead_zeros;
                        end
                    end
                end
                ST_RUN: begin
                    rem_q  <= rem_nx;
                    work_q <= work_nx;
                    cnt_q  <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) begin
                        state_q  <= ST_IDLE;
                        done     <= 1'b1;
                        div_zero <= 1'b0;
                        quotient <= neg_q ? (~work_nx + 1'b1) : work_nx;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Busy follows the loop state.
    assign busy = (state_q == ST_RUN);
endmodule

// File: rtl/intdiv_seq_checker.sv
// Protocol and corner-case properties for intdiv_seq, bound to every instance.
// Tracks only whether the accepted operands were the signed overflow pair.
module intdiv_seq_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         is_signed,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic         div_zero
);
    logic minneg_q;

    // Remember whether the accepted request was most-negative divided by -1.
    always_ff @(posedge clk) begin
        if (!rst_n) minneg_q <= 1'b0;
        else if (start && !busy)
            minneg_q <= is_signed && (dividend == {1'b1, {(W-1){1'b0}}}) && (divisor == '1);
    end

    p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && minneg_q) |-> (quotient == {1'b1, {(W-1){1'b0}}} && !div_zero));

    p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (done && div_zero && quotient == '0));

    p_busy_until_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(div_zero)));

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !div_zero && quotient == '0));
endmodule

bind intdiv_seq intdiv_seq_checker #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .div_zero  (div_zero)
);

// File: tb/test_intdiv_seq.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model compared on every falling edge, plus
// directed checks of results and latency.
module test_intdiv_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy;
    logic        done;
    logic [31:0] quotient;
    logic        div_zero;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    intdiv_seq i_intdiv_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .div_zero(div_zero)
    );

    // Quotient from integer arithmetic: truncation toward zero, 0 for a zero divisor.
    function automatic logic [31:0] ref_q(logic [31:0] n, logic [31:0] d, logic s);
        longint a, b;
        if (d == 0) return 32'h0;
        if (s) begin a = longint'($signed(n)); b = longint'($signed(d)); end
        else begin a = longint'(n); b = longint'(d); end
        return 32'(a / b);
    endfunction

    // Bit length of the dividend magnitude.
    function automatic int bitlen(logic [31:0] n, logic s);
        logic [31:0] m;
        int len;
        m = (s && n[31]) ? -n : n;
        len = 0;
        for (int i = 0; i < 32; i++) if (m[i]) len = i + 1;
        return len;
    endfunction

    // Cycle model.
    bit          m_busy = 0, m_done = 0, m_dz = 0;
    logic [31:0] m_q = '0, m_pend = '0;
    int          m_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_q = '0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_q = m_pend; m_dz = 0;
                end
            end else if (start) begin
                if (divisor == 0 || dividend == 0) begin
                    m_done = 1; m_q = '0; m_dz = (divisor == 0);
                end else begin
                    m_busy = 1;
                    m_cnt  = bitlen(dividend, is_signed);
                    m_pend = ref_q(dividend, divisor, is_signed);
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs against the model every cycle.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R5 busy", 32'(busy), 32'(m_busy));
            check("R6 done", 32'(done), 32'(m_done));
            check("R1/R2 quotient", quotient, m_q);
            check("R4 div_zero", 32'(div_zero), 32'(m_dz));
        end
    end

    // Directed division with result, status and latency checks.
    task automatic run_div(string tag, logic [31:0] n, logic [31:0] d, logic s,
                           logic [31:0] exp_q, logic exp_dz, int exp_lat);
        int lat;
        @(negedge clk);
        dividend = n; divisor = d; is_signed = s; start = 1'b1;
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done) begin lat++; @(negedge clk); end
        check(tag, quotient, exp_q);
        check({tag, " div_zero"}, 32'(div_zero), 32'(exp_dz));
        check("R5 latency", 32'(lat), 32'(exp_lat));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9 busy", 32'(busy), 0);
        check("R9 done", 32'(done), 0);
        check("R9 quotient", quotient, 0);
        check("R9 div_zero", 32'(div_zero), 0);
        rst_n = 1'b1;

        // R1: unsigned examples.
        run_div("R1 15/4", 32'd15, 32'd4, 1'b0, 32'd3, 1'b0, 5);
        run_div("R1 4/15", 32'd4, 32'd15, 1'b0, 32'd0, 1'b0, 4);
        run_div("R1 msb", 32'h80000000, 32'h40000000, 1'b0, 32'd2, 1'b0, 33);
        run_div("R1 max/1", 32'hFFFFFFFF, 32'd1, 1'b0, 32'hFFFFFFFF, 1'b0, 33);
        // R2: signed truncation toward zero.
        run_div("R2 15/4", 32'd15, 32'd4, 1'b1, 32'd3, 1'b0, 5);
        run_div("R2 -15/4", -32'd15, 32'd4, 1'b1, -32'd3, 1'b0, 5);
        run_div("R2 4/-3", 32'd4, -32'd3, 1'b1, -32'd1, 1'b0, 4);
        run_div("R2 -4/-3", -32'd4, -32'd3, 1'b1, 32'd1, 1'b0, 4);
        // R3: overflow corner.
        run_div("R3 min/-1", 32'h80000000, 32'hFFFFFFFF, 1'b1, 32'h80000000, 1'b0, 33);
        // R4: zero divisor in both modes.
        run_div("R4 u x/0", 32'd77, 32'd0, 1'b0, 32'd0, 1'b1, 1);
        run_div("R4 s x/0", -32'd9, 32'd0, 1'b1, 32'd0, 1'b1, 1);
        // R5: zero dividend and a one-bit dividend.
        run_div("R5 0/x", 32'd0, 32'd7, 1'b1, 32'd0, 1'b0, 1);
        run_div("R5 1/1", 32'd1, 32'd1, 1'b0, 32'd1, 1'b0, 2);

        // R7: start while busy is ignored.
        @(negedge clk);
        dividend = 32'h80000000; divisor = 32'd3; is_signed = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        dividend = 32'd5; divisor = 32'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        check("R7 quotient", quotient, 32'h2AAAAAAA);
        check("R7 div_zero", 32'(div_zero), 0);

        // R8: outputs hold while idle with new inputs.
        @(negedge clk);
        dividend = 32'd100; divisor = 32'd0; is_signed = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 quotient hold", quotient, 32'h2AAAAAAA);
        check("R8 div_zero hold", 32'(div_zero), 0);
        check("R6 done low", 32'(done), 0);

        // Mixed operands, including occasional start while busy.
        for (int k = 0; k < 300; k++) begin
            logic [31:0] n, d;
            n = $urandom >> ($urandom % 32);
            case ($urandom % 8)
                0: d = 32'h0;
                1: d = 32'hFFFFFFFF;
                2: d = $urandom % 16;
                default: d = $urandom >> ($urandom % 32);
            endcase
            if ($urandom % 2) n = -n;
            @(negedge clk);
            dividend = n; divisor = d; is_signed = 1'($urandom); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (busy && ($urandom % 4 == 0)) begin
                dividend = $urandom; divisor = $urandom; start = 1'b1;
                @(negedge clk); start = 1'b0;
            end
            while (!done) @(negedge clk);
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule